// File: doc/BRIEF.md
# Micro Translation Cache with Backing-TLB Refill

This block is a small, fully associative address translation cache built from flip-flops. It sits in front of a larger main TLB. A requester presents a virtual page number and a process identifier. When a valid local entry matches, the block returns the physical frame number and the permission bits in the same cycle.

When no local entry matches, the block stalls the requester and queries the main TLB through a simple request/response port. A main-TLB hit returns the translation to the requester and copies the entry into the cache. The copy goes into an empty slot if one exists; otherwise it replaces the least-recently-used slot. A main-TLB miss raises a one-cycle translation exception and installs nothing.

The cache holds only copies of main-TLB entries, and software cannot read or write it. Every entry is invalidated when the main TLB is written or when the control register holding the current process identifier is written.

Top module: `utlb_cache`

## Requirements
- R1: The number of entries is the parameter ENTRIES (default 6; 4 is the usual instruction-side size). After reset every entry is invalid, so the first lookup misses and outputs done, stall, xcpt and mtlb_req are 0 while no request is present.
- R2: A local entry matches only when it is valid and its VPN equals req_vpn. A matching entry answers in the same cycle as req_valid with done=1, stall=0 and its stored PFN and permissions, and mtlb_req stays 0.
- R3: A non-global entry matches only when its stored PID equals req_pid. An entry installed with the global flag set matches every PID.
- R4: On a local miss, stall is 1 in the request cycle. From the next cycle mtlb_req is 1, with mtlb_vpn and mtlb_pid held at the missed request. Both mtlb_req and stall stay 1 until the cycle in which mtlb_rsp_valid is 1.
- R5: In the cycle of a main-TLB response with mtlb_rsp_hit=1, done=1 and the response PFN and permissions are output. The entry is installed, so the same lookup afterwards hits locally.
- R6: In the cycle of a main-TLB response with mtlb_rsp_hit=0, xcpt=1 and done=0. Nothing is installed, so the same lookup misses again.
- R7: A fill uses the lowest-numbered invalid entry, if one exists, before any eviction, so ENTRIES distinct fills all remain resident.
- R8: When all entries are valid, a fill replaces the least-recently-used entry. Both local hits and fills count as uses.
- R9: A pulse on tlb_wr invalidates all entries at the next clock edge.
- R10: A pulse on pid_wr invalidates all entries at the next clock edge.
- R11: A flush that occurs while a main-TLB query is outstanding, or in the cycle of its response, does not stop the response from being delivered. The response is not installed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_vpn | input | VPN_W | Virtual page number to translate |
| req_pid | input | PID_W | Process identifier of the request |
| tlb_wr | input | 1 | Main TLB was written (flush) |
| pid_wr | input | 1 | PID control register was written (flush) |
| done | output | 1 | Translation valid this cycle |
| stall | output | 1 | Requester must wait |
| xcpt | output | 1 | Translation exception (main-TLB miss) |
| rsp_pfn | output | PFN_W | Physical frame number |
| rsp_perm | output | PERM_W | Permission bits |
| mtlb_req | output | 1 | Query to main TLB outstanding |
| mtlb_vpn | output | VPN_W | VPN sent to main TLB |
| mtlb_pid | output | PID_W | PID sent to main TLB |
| mtlb_rsp_valid | input | 1 | Main TLB response present |
| mtlb_rsp_hit | input | 1 | Main TLB found a translation |
| mtlb_rsp_pfn | input | PFN_W | PFN from main TLB |
| mtlb_rsp_perm | input | PERM_W | Permissions from main TLB |
| mtlb_rsp_global | input | 1 | Entry from main TLB is global |

## Verification
The bench builds the block with ENTRIES=4, VPN_W=8, PID_W=4, PFN_W=8 and PERM_W=3. Four entries let a few accesses fill the cache and force an eviction, so the empty-slot preference and the least-recently-used order are both exercised. An 8-bit VPN lets the bench's main-TLB model cover a miss range and a global range with simple computed tables. A 4-bit PID leaves room for distinct processes in the PID-mismatch and global-match cases.

// File: rtl/utlb_pkg.sv
package utlb_pkg;
   typedef enum logic {
      UT_IDLE = 1'b0,
      UT_WAIT = 1'b1
   } utlb_state_e;
endpackage

// File: rtl/utlb_match.sv
module utlb_match #(
   parameter int ENTRIES = 6,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic [ENTRIES-1:0]            ent_valid,
   input  logic [ENTRIES-1:0]            ent_glob,
   input  logic [ENTRIES-1:0][VPN_W-1:0] ent_vpn,
   input  logic [ENTRIES-1:0][PID_W-1:0] ent_pid,
   input  logic [VPN_W-1:0]              key_vpn,
   input  logic [PID_W-1:0]              key_pid,
   output logic                          hit,
   output logic [IDX_W-1:0]              hit_idx
);
   logic [ENTRIES-1:0] line_hit;

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign line_hit[g] = ent_valid[g] && (ent_vpn[g] == key_vpn) &&
                           (ent_glob[g] || (ent_pid[g] == key_pid));
   end

   // lowest index wins when a global and a private copy overlap
   always_comb begin
      hit_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (line_hit[i]) hit_idx = IDX_W'(i);
      end
   end

   assign hit = |line_hit;
endmodule

// File: rtl/utlb_lru.sv
module utlb_lru #(
   parameter int ENTRIES = 6,
   localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               touch,
   input  logic [IDX_W-1:0]   touch_idx,
   input  logic [ENTRIES-1:0] occupied,
   output logic [IDX_W-1:0]   victim_idx
);
   // age rank per entry: 0 = most recent, ENTRIES-1 = least recent
   logic [ENTRIES-1:0][IDX_W-1:0] age_q;
   logic [IDX_W-1:0]              touched_age;

   assign touched_age = age_q[touch_idx];

   for (genvar g = 0; g < ENTRIES; g++) begin : g_age
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            age_q[g] <= IDX_W'(g);
         end else if (touch) begin
            if (touch_idx == IDX_W'(g))          age_q[g] <= '0;
            else if (age_q[g] < touched_age)     age_q[g] <= age_q[g] + 1'b1;
         end
      end
   end

   always_comb begin
      logic found;
      found      = 1'b0;
      victim_idx = '0;
      for (int i = 0; i < ENTRIES; i++) begin
         if (!found && !occupied[i]) begin
            victim_idx = IDX_W'(i);
            found      = 1'b1;
         end
      end
      if (!found) begin
         for (int i = 0; i < ENTRIES; i++) begin
            if (age_q[i] == IDX_W'(ENTRIES - 1)) victim_idx = IDX_W'(i);
         end
      end
   end
endmodule

// File: rtl/utlb_cache.sv
module utlb_cache
   import utlb_pkg::*;
#(
   parameter int ENTRIES = 6,
   parameter int VPN_W   = 20,
   parameter int PID_W   = 8,
   parameter int PFN_W   = 20,
   parameter int PERM_W  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [VPN_W-1:0]  req_vpn,
   input  logic [PID_W-1:0]  req_pid,
   input  logic              tlb_wr,
   input  logic              pid_wr,
   output logic              done,
   output logic              stall,
   output logic              xcpt,
   output logic [PFN_W-1:0]  rsp_pfn,
   output logic [PERM_W-1:0] rsp_perm,
   output logic              mtlb_req,
   output logic [VPN_W-1:0]  mtlb_vpn,
   output logic [PID_W-1:0]  mtlb_pid,
   input  logic              mtlb_rsp_valid,
   input  logic              mtlb_rsp_hit,
   input  logic [PFN_W-1:0]  mtlb_rsp_pfn,
   input  logic [PERM_W-1:0] mtlb_rsp_perm,
   input  logic              mtlb_rsp_global
);
   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("utlb_cache: ENTRIES must lie in 2..64");
   end
   if (VPN_W < 1 || PID_W < 1 || PFN_W < 1 || PERM_W < 1) begin : g_bad_width
      $error("utlb_cache: field widths must be positive");
   end

   logic [ENTRIES-1:0]             ent_valid;
   logic [ENTRIES-1:0]             ent_glob;
   logic [ENTRIES-1:0][VPN_W-1:0]  ent_vpn;
   logic [ENTRIES-1:0][PID_W-1:0]  ent_pid;
   logic [ENTRIES-1:0][PFN_W-1:0]  ent_pfn;
   logic [ENTRIES-1:0][PERM_W-1:0] ent_perm;

   utlb_state_e       state_q;
   logic [VPN_W-1:0]  miss_vpn_q;
   logic [PID_W-1:0]  miss_pid_q;
   logic              drop_q;

   logic              lhit;
   logic [IDX_W-1:0]  lhit_idx;
   logic [IDX_W-1:0]  victim;
   logic              flush, idle, local_hit, local_miss, arrive, fill, touch;
   logic [IDX_W-1:0]  touch_idx;

   utlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W)) i_match (
      .ent_valid (ent_valid),
      .ent_glob  (ent_glob),
      .ent_vpn   (ent_vpn),
      .ent_pid   (ent_pid),
      .key_vpn   (req_vpn),
      .key_pid   (req_pid),
      .hit       (lhit),
      .hit_idx   (lhit_idx)
   );

   assign flush      = tlb_wr | pid_wr;
   assign idle       = (state_q == UT_IDLE);
   assign local_hit  = idle && req_valid && lhit;
   assign local_miss = idle && req_valid && !lhit;
   assign arrive     = (state_q == UT_WAIT) && mtlb_rsp_valid;
   assign fill       = arrive && mtlb_rsp_hit && !drop_q && !flush;
   assign touch      = local_hit | fill;
   assign touch_idx  = local_hit ? lhit_idx : victim;

   utlb_lru #(.ENTRIES(ENTRIES)) i_lru (
      .clk        (clk),
      .rst_n      (rst_n),
      .touch      (touch),
      .touch_idx  (touch_idx),
      .occupied   (ent_valid),
      .victim_idx (victim)
   );

   // control sequence
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q    <= UT_IDLE;
         miss_vpn_q <= '0;
         miss_pid_q <= '0;
         drop_q     <= 1'b0;
      end else begin
         case (state_q)
            UT_IDLE: if (local_miss) begin
               state_q    <= UT_WAIT;
               miss_vpn_q <= req_vpn;
               miss_pid_q <= req_pid;
               drop_q     <= flush;
            end
            UT_WAIT: begin
               if (mtlb_rsp_valid) begin
                  state_q <= UT_IDLE;
                  drop_q  <= 1'b0;
               end else if (flush) begin
                  drop_q  <= 1'b1;
               end
            end
            default: state_q <= UT_IDLE;
         endcase
      end
   end

   // entry valid bits
   always_ff @(posedge clk) begin
      if (!rst_n)     ent_valid <= '0;
      else if (flush) ent_valid <= '0;
      else if (fill)  ent_valid[victim] <= 1'b1;
   end

   // entry payload, written only on fill
   always_ff @(posedge clk) begin
      if (fill) begin
         ent_vpn[victim]  <= miss_vpn_q;
         ent_pid[victim]  <= miss_pid_q;
         ent_glob[victim] <= mtlb_rsp_global;
         ent_pfn[victim]  <= mtlb_rsp_pfn;
         ent_perm[victim] <= mtlb_rsp_perm;
      end
   end

   assign done     = local_hit | (arrive && mtlb_rsp_hit);
   assign xcpt     = arrive && !mtlb_rsp_hit;
   assign stall    = local_miss | ((state_q == UT_WAIT) && !mtlb_rsp_valid);
   assign rsp_pfn  = local_hit ? ent_pfn[lhit_idx]  : mtlb_rsp_pfn;
   assign rsp_perm = local_hit ? ent_perm[lhit_idx] : mtlb_rsp_perm;
   assign mtlb_req = (state_q == UT_WAIT);
   assign mtlb_vpn = miss_vpn_q;
   assign mtlb_pid = miss_pid_q;
endmodule

// File: rtl/utlb_checker.sv
module utlb_checker #(
   parameter int VPN_W = 20,
   parameter int PID_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             tlb_wr,
   input logic             pid_wr,
   input logic             done,
   input logic             stall,
   input logic             xcpt,
   input logic             mtlb_req,
   input logic [VPN_W-1:0] mtlb_vpn,
   input logic [PID_W-1:0] mtlb_pid,
   input logic             mtlb_rsp_valid,
   input logic             mtlb_rsp_hit
);
   assert_done_no_stall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !stall);

   assert_query_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mtlb_req && !mtlb_rsp_valid) |=> (mtlb_req && $stable(mtlb_vpn) && $stable(mtlb_pid)));

   assert_query_stalls_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mtlb_req && !mtlb_rsp_valid) |-> stall);

   assert_xcpt_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      xcpt |-> (mtlb_req && mtlb_rsp_valid && !mtlb_rsp_hit && !done));

   assert_tlbwr_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
      tlb_wr |=> !(done && !mtlb_req));

   assert_pidwr_flush_R10: assert property (@(posedge clk) disable iff (!rst_n)
      pid_wr |=> !(done && !mtlb_req));
endmodule

bind utlb_cache utlb_checker #(.VPN_W(VPN_W), .PID_W(PID_W)) i_utlb_checker (
   .clk            (clk),
   .rst_n          (rst_n),
   .tlb_wr         (tlb_wr),
   .pid_wr         (pid_wr),
   .done           (done),
   .stall          (stall),
   .xcpt           (xcpt),
   .mtlb_req       (mtlb_req),
   .mtlb_vpn       (mtlb_vpn),
   .mtlb_pid       (mtlb_pid),
   .mtlb_rsp_valid (mtlb_rsp_valid),
   .mtlb_rsp_hit   (mtlb_rsp_hit)
);

// File: tb/test_utlb_cache.sv
module test_utlb_cache;
   localparam int ENTRIES = 4;
   localparam int VPN_W   = 8;
   localparam int PID_W   = 4;
   localparam int PFN_W   = 8;
   localparam int PERM_W  = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [VPN_W-1:0] req_vpn = '0;
   logic [PID_W-1:0] req_pid = '0;
   logic tlb_wr = 1'b0, pid_wr = 1'b0;
   logic done, stall, xcpt, mtlb_req;
   logic [PFN_W-1:0] rsp_pfn;
   logic [PERM_W-1:0] rsp_perm;
   logic [VPN_W-1:0] mtlb_vpn;
   logic [PID_W-1:0] mtlb_pid;
   logic mtlb_rsp_valid = 1'b0, mtlb_rsp_hit = 1'b0, mtlb_rsp_global = 1'b0;
   logic [PFN_W-1:0] mtlb_rsp_pfn = '0;
   logic [PERM_W-1:0] mtlb_rsp_perm = '0;

   int checks = 0;
   int failures = 0;

   always #10 clk = ~clk;   // 50 MHz

   utlb_cache #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .PID_W(PID_W),
                .PFN_W(PFN_W), .PERM_W(PERM_W)) i_utlb_cache (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vpn(req_vpn),
      .req_pid(req_pid), .tlb_wr(tlb_wr), .pid_wr(pid_wr), .done(done),
      .stall(stall), .xcpt(xcpt), .rsp_pfn(rsp_pfn), .rsp_perm(rsp_perm),
      .mtlb_req(mtlb_req), .mtlb_vpn(mtlb_vpn), .mtlb_pid(mtlb_pid),
      .mtlb_rsp_valid(mtlb_rsp_valid), .mtlb_rsp_hit(mtlb_rsp_hit),
      .mtlb_rsp_pfn(mtlb_rsp_pfn), .mtlb_rsp_perm(mtlb_rsp_perm),
      .mtlb_rsp_global(mtlb_rsp_global)
   );

   // main TLB model: VPN C0..EF absent, F0..FF global
   function automatic logic mt_hit(input logic [7:0] v);
      return (v < 8'hC0) || (v >= 8'hF0);
   endfunction
   function automatic logic [7:0] mt_pfn(input logic [7:0] v);
      return v ^ 8'hA5;
   endfunction
   function automatic logic [2:0] mt_perm(input logic [7:0] v);
      return v[2:0] ^ 3'b101;
   endfunction

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
      end
   endtask

   // one translation; exp_local: expect same-cycle hit; flush_mid: tlb_wr while waiting
   task automatic access(input logic [7:0] vpn, input logic [3:0] pid,
                         input bit exp_local, input bit flush_mid, input string req);
      @(negedge clk);
      req_valid = 1'b1; req_vpn = vpn; req_pid = pid;
      #5;
      if (exp_local) begin
         chk(done && !stall && !mtlb_req, req, "local hit done", {29'd0, done, stall, mtlb_req}, 32'h4);
         chk(rsp_pfn == mt_pfn(vpn), req, "local pfn", rsp_pfn, mt_pfn(vpn));
         chk(rsp_perm == mt_perm(vpn), req, "local perm", rsp_perm, mt_perm(vpn));
         @(negedge clk);
         req_valid = 1'b0;
      end else begin
         chk(stall && !done, req, "miss stall", {30'd0, stall, done}, 32'h2);
         @(negedge clk);
         req_valid = 1'b0;
         if (flush_mid) tlb_wr = 1'b1;
         for (int k = 0; k < 2; k++) begin
            #1;
            chk(mtlb_req && stall && mtlb_vpn == vpn && mtlb_pid == pid, "R4",
                "query held", {22'd0, mtlb_req, stall, mtlb_vpn}, {22'd0, 2'b11, vpn});
            @(negedge clk);
            tlb_wr = 1'b0;
         end
         mtlb_rsp_valid = 1'b1; mtlb_rsp_hit = mt_hit(vpn);
         mtlb_rsp_pfn = mt_pfn(vpn); mtlb_rsp_perm = mt_perm(vpn);
         mtlb_rsp_global = (vpn >= 8'hF0);
         #5;
         if (mt_hit(vpn)) begin
            chk(done && !xcpt && !stall, "R5", "refill done", {29'd0, done, xcpt, stall}, 32'h4);
            chk(rsp_pfn == mt_pfn(vpn), "R5", "refill pfn", rsp_pfn, mt_pfn(vpn));
         end else begin
            chk(xcpt && !done && !stall, "R6", "exception", {29'd0, xcpt, done, stall}, 32'h4);
         end
         @(negedge clk);
         mtlb_rsp_valid = 1'b0; mtlb_rsp_hit = 1'b0; mtlb_rsp_global = 1'b0;
         #1;
         chk(!xcpt && !done && !mtlb_req, req, "back to idle", {29'd0, xcpt, done, mtlb_req}, 32'h0);
      end
   endtask

   task automatic pulse(input bit use_pid);
      @(negedge clk);
      if (use_pid) pid_wr = 1'b1; else tlb_wr = 1'b1;
      @(negedge clk);
      pid_wr = 1'b0; tlb_wr = 1'b0;
   endtask

   task automatic t_reset;
      #1;
      chk(!done && !stall && !xcpt && !mtlb_req, "R1", "reset idle outputs",
          {28'd0, done, stall, xcpt, mtlb_req}, 32'h0);
      access(8'h10, 4'd1, 1'b0, 1'b0, "R1");
   endtask

   task automatic t_hit_and_pid;
      access(8'h10, 4'd1, 1'b1, 1'b0, "R2");
      access(8'h10, 4'd1, 1'b1, 1'b0, "R5");
      access(8'h10, 4'd2, 1'b0, 1'b0, "R3");
      access(8'hF1, 4'd1, 1'b0, 1'b0, "R3");
      access(8'hF1, 4'd7, 1'b1, 1'b0, "R3");
   endtask

   task automatic t_exception;
      access(8'hC5, 4'd1, 1'b0, 1'b0, "R6");
      access(8'hC5, 4'd1, 1'b0, 1'b0, "R6");
   endtask

   task automatic t_flushes;
      pulse(1'b0);
      access(8'h10, 4'd1, 1'b0, 1'b0, "R9");
      access(8'h10, 4'd1, 1'b1, 1'b0, "R9");
      pulse(1'b1);
      access(8'h10, 4'd1, 1'b0, 1'b0, "R10");
   endtask

   task automatic t_fill_lru;
      pulse(1'b0);
      for (int v = 1; v <= ENTRIES; v++) access(8'(v), 4'd0, 1'b0, 1'b0, "R7");
      for (int v = 1; v <= ENTRIES; v++) access(8'(v), 4'd0, 1'b1, 1'b0, "R7");
      access(8'h01, 4'd0, 1'b1, 1'b0, "R8");        // 02 is now least recent
      access(8'h05, 4'd0, 1'b0, 1'b0, "R8");        // evicts 02
      access(8'h01, 4'd0, 1'b1, 1'b0, "R8");
      access(8'h03, 4'd0, 1'b1, 1'b0, "R8");
      access(8'h04, 4'd0, 1'b1, 1'b0, "R8");
      access(8'h05, 4'd0, 1'b1, 1'b0, "R8");
      access(8'h02, 4'd0, 1'b0, 1'b0, "R8");
   endtask

   task automatic t_flush_mid;
      pulse(1'b0);
      access(8'h20, 4'd3, 1'b0, 1'b1, "R11");
      access(8'h20, 4'd3, 1'b0, 1'b0, "R11");
      access(8'h20, 4'd3, 1'b1, 1'b0, "R11");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_hit_and_pid();
      t_exception();
      t_flushes();
      t_fill_lru();
      t_flush_mid();
      repeat (2) @(negedge clk);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule